// File: doc/BRIEF.md
# GPIO Edge and Level Interrupt Detector

This block turns an 8-bit input port into one interrupt request. Each clock it compares the present pin vector with the sample it took on the previous clock. Pins configured as outputs are left out of that comparison. Per-pin configuration then decides which pins raise a status bit: a sense vector picks edge or level detection, a polarity vector picks the active edge or level, and a dual-edge vector lets an edge-mode pin fire on either transition. Status bits are sticky. Software clears them by writing ones. A mask vector gates the status bits into the single interrupt line.

Software reaches the block through a simple synchronous register port with a write strobe, an address, write data and combinational read data. The port exposes sense, dual-edge, polarity, mask, raw status, masked status and the write-one-to-clear location. Pin synchronisation and the data and direction registers belong to the surrounding port. This block receives the current data and direction vectors already in the clock domain.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset every configuration vector, the raw status and the pin history are zero, and `irq` is low.
- R2: A pin counts as changed only if its direction bit is 0 (input) and its value differs from the previous clock's sample. The sample is refreshed every clock for all pins, so an output pin that later becomes an input does not report a stale change.
- R3: With sense bit 0 and dual-edge bit 0, a changed pin sets its status bit only if its new value equals its polarity bit (1 = rising, 0 = falling). An unchanged edge-mode pin never sets a status bit.
- R4: With sense bit 0 and dual-edge bit 1, any change of the pin sets its status bit.
- R5: With sense bit 1, the status bit is set on every clock on which the pin value equals the polarity bit (1 = high, 0 = low). Once the sense bit returns to 0, the level no longer sets the bit.
- R6: A write to offset 0x41C clears each status bit whose data bit is 1 and leaves bits written 0 unchanged. A clear wins over a set in the same clock, so a still-active level sets the bit again one clock later.
- R7: `irq` is high exactly when some bit of raw status AND mask is 1. Offset 0x418 reads that AND.
- R8: Offsets are sense 0x404, dual-edge 0x408, polarity 0x40C, mask 0x410 and raw status 0x414. Each register holds 8 bits, and reads are zero-extended to 32 bits. A read of the clear offset or of any other address returns 0.
- R9: A pin change is visible in raw status after the next rising clock edge. A configuration write takes effect from the clock after the write edge, so a level condition it enables shows in status one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_data | input | 8 | Current pin values, already synchronous to clk |
| pin_dir | input | 8 | Pin direction, 1 = output, 0 = input |
| reg_wr_en | input | 1 | Single-cycle register write strobe |
| reg_addr | input | 12 | Register byte offset for reads and writes |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| irq | output | 1 | Combined masked interrupt request |

## Verification
The assertions assume that `pin_data`, `pin_dir` and the register port are synchronous to `clk` and carry known values from reset onward. They also assume that a write lasts exactly one cycle at one address, because the clear and set properties look one edge back at the strobe. The stimulus changes pins, direction and bus signals only on the falling edge. It holds each value for at least a full cycle and never leaves a signal undriven. This keeps every sampled value inside what those properties expect.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // Port width of the detector and of its register fields
  localparam int unsigned PIN_W = 8;
  localparam int unsigned OFF_W = 12;
  localparam int unsigned N_CFG = 4;

  typedef logic [PIN_W-1:0] pin_vec_t;
  typedef logic [OFF_W-1:0] off_t;

  // Configuration slots; order fixes their offsets (4 bytes apart)
  typedef enum logic [1:0] {
    CFG_SENSE = 2'd0,
    CFG_DUAL  = 2'd1,
    CFG_POL   = 2'd2,
    CFG_MASK  = 2'd3
  } cfg_sel_e;

  localparam off_t OFF_CFG_BASE = 12'h404;
  localparam off_t OFF_RAW      = 12'h414;
  localparam off_t OFF_MASKED   = 12'h418;
  localparam off_t OFF_CLEAR    = 12'h41C;

  function automatic off_t cfg_offset(input int unsigned idx);
    return OFF_CFG_BASE + (off_t'(idx) << 2);
  endfunction

  // Input pins whose value moved since the last sample
  function automatic pin_vec_t f_changed(input pin_vec_t now_v, input pin_vec_t last_v,
                                         input pin_vec_t dir_v);
    return (now_v ^ last_v) & ~dir_v;
  endfunction

  // Edge-mode hits: dual-edge takes any change, else the new value must match polarity
  function automatic pin_vec_t f_edge_hit(input pin_vec_t chg_v, input pin_vec_t now_v,
                                          input pin_vec_t sense_v, input pin_vec_t dual_v,
                                          input pin_vec_t pol_v);
    return chg_v & ~sense_v & (dual_v | ~(now_v ^ pol_v));
  endfunction

  // Level-mode hits: pin sits at its polarity
  function automatic pin_vec_t f_level_hit(input pin_vec_t now_v, input pin_vec_t sense_v,
                                           input pin_vec_t pol_v);
    return sense_v & ~(now_v ^ pol_v);
  endfunction

  // Sticky status update; a clear in the same cycle beats a set
  function automatic logic f_status_bit(input logic cur, input logic set_b, input logic clr_b);
    return (cur | set_b) & ~clr_b;
  endfunction

endpackage

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
  import gpio_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [PIN_W-1:0]              wdata,
  output logic [N_CFG-1:0][PIN_W-1:0]   cfg_q
);

  generate
    for (genvar g = 0; g < N_CFG; g++) begin : g_slot
      logic hit;
      assign hit = wr_en && (addr == ADDR_W'(cfg_offset(g)));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cfg_q[g] <= '0;
        end else if (hit) begin
          cfg_q[g] <= wdata;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/gpio_irq_detect_core.sv
module gpio_irq_detect_core
  import gpio_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIN_W-1:0] pin_data,
  input  logic [PIN_W-1:0] pin_dir,
  input  logic [PIN_W-1:0] sense,
  input  logic [PIN_W-1:0] dual,
  input  logic [PIN_W-1:0] pol,
  output logic [PIN_W-1:0] prev_q,
  output logic [PIN_W-1:0] edge_hit,
  output logic [PIN_W-1:0] level_hit
);

  logic [PIN_W-1:0] changed;

  // History of every pin, refreshed each clock regardless of direction
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
    end else begin
      prev_q <= pin_data;
    end
  end

  always_comb begin
    changed   = f_changed(pin_data, prev_q, pin_dir);
    edge_hit  = f_edge_hit(changed, pin_data, sense, dual, pol);
    level_hit = f_level_hit(pin_data, sense, pol);
  end

endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status
  import gpio_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIN_W-1:0] set_vec,
  input  logic [PIN_W-1:0] clr_vec,
  input  logic [PIN_W-1:0] mask,
  output logic [PIN_W-1:0] raw_q,
  output logic             irq
);

  generate
    for (genvar g = 0; g < PIN_W; g++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          raw_q[g] <= 1'b0;
        end else begin
          raw_q[g] <= f_status_bit(raw_q[g], set_vec[g], clr_vec[g]);
        end
      end
    end
  endgenerate

  assign irq = |(raw_q & mask);

endmodule

// File: rtl/gpio_irq_rdmux.sv
module gpio_irq_rdmux
  import gpio_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic [ADDR_W-1:0]           addr,
  input  logic [N_CFG-1:0][PIN_W-1:0] cfg_q,
  input  logic [PIN_W-1:0]            raw_q,
  output logic [DATA_W-1:0]           rdata
);

  always_comb begin
    rdata = '0;
    for (int i = 0; i < N_CFG; i++) begin
      if (addr == ADDR_W'(cfg_offset(i))) begin
        rdata[PIN_W-1:0] = cfg_q[i];
      end
    end
    if (addr == ADDR_W'(OFF_RAW)) begin
      rdata[PIN_W-1:0] = raw_q;
    end
    if (addr == ADDR_W'(OFF_MASKED)) begin
      rdata[PIN_W-1:0] = raw_q & cfg_q[CFG_MASK];
    end
  end

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PIN_W-1:0]  pin_data,
  input  logic [PIN_W-1:0]  pin_dir,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [PIN_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);

  logic [N_CFG-1:0][PIN_W-1:0] cfg_q;
  logic [PIN_W-1:0] sense_q, dual_q, pol_q, mask_q;
  logic [PIN_W-1:0] prev_q, edge_hit, level_hit, set_vec, clr_vec, raw_q;
  logic             clr_hit;

  assign sense_q = cfg_q[CFG_SENSE];
  assign dual_q  = cfg_q[CFG_DUAL];
  assign pol_q   = cfg_q[CFG_POL];
  assign mask_q  = cfg_q[CFG_MASK];

  assign clr_hit = reg_wr_en && (reg_addr == ADDR_W'(OFF_CLEAR));
  assign clr_vec = clr_hit ? reg_wdata : '0;
  assign set_vec = edge_hit | level_hit;

  gpio_irq_cfg #(.ADDR_W(ADDR_W)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (reg_wr_en),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .cfg_q (cfg_q)
  );

  gpio_irq_detect_core u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_data  (pin_data),
    .pin_dir   (pin_dir),
    .sense     (sense_q),
    .dual      (dual_q),
    .pol       (pol_q),
    .prev_q    (prev_q),
    .edge_hit  (edge_hit),
    .level_hit (level_hit)
  );

  gpio_irq_status u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .mask    (mask_q),
    .raw_q   (raw_q),
    .irq     (irq)
  );

  gpio_irq_rdmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rdmux (
    .addr  (reg_addr),
    .cfg_q (cfg_q),
    .raw_q (raw_q),
    .rdata (reg_rdata)
  );

endmodule

// File: rtl/gpio_irq_detect_chk.sv
module gpio_irq_detect_chk
  import gpio_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PIN_W-1:0]  pin_data,
  input logic [PIN_W-1:0]  pin_dir,
  input logic              reg_wr_en,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [PIN_W-1:0]  reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              irq,
  input logic [PIN_W-1:0]  raw_q,
  input logic [PIN_W-1:0]  mask_q,
  input logic [PIN_W-1:0]  sense_q,
  input logic [PIN_W-1:0]  prev_q,
  input logic [PIN_W-1:0]  level_hit,
  input logic [PIN_W-1:0]  clr_vec
);

  // R2: an output pin in edge mode never raises a new status bit
  p_outdir_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw_q & ~$past(raw_q) & $past(pin_dir & ~sense_q)) == '0));

  // R3: an edge-mode pin equal to its history never raises a new status bit
  p_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw_q & ~$past(raw_q) & $past(~sense_q & ~(pin_data ^ prev_q))) == '0));

  // R5: an active level not being cleared shows in status on the next edge
  p_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (level_hit != '0) |=> (($past(level_hit & ~clr_vec) & ~raw_q) == '0));

  // R6: bits written 1 to the clear offset are 0 after the edge
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == ADDR_W'(OFF_CLEAR)) |=> ((raw_q & $past(reg_wdata)) == '0));

  // R6: without a clear write, status bits only accumulate
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_en && reg_addr == ADDR_W'(OFF_CLEAR)) |=> (($past(raw_q) & ~raw_q) == '0));

  // R7: masked-status read agrees with raw status and mask
  p_mis_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(OFF_MASKED)) |-> (reg_rdata == DATA_W'(raw_q & mask_q)));

  // R7: interrupt line agrees with the masked-status read
  p_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(OFF_MASKED)) |-> (irq == (reg_rdata != '0)));

endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pin_data  (pin_data),
  .pin_dir   (pin_dir),
  .reg_wr_en (reg_wr_en),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .irq       (irq),
  .raw_q     (raw_q),
  .mask_q    (mask_q),
  .sense_q   (sense_q),
  .prev_q    (prev_q),
  .level_hit (level_hit),
  .clr_vec   (clr_vec)
);

// File: tb/gpio_irq_detect_bench.sv
module gpio_irq_detect_bench;

  localparam logic [11:0] A_SENSE = 12'h404;
  localparam logic [11:0] A_DUAL  = 12'h408;
  localparam logic [11:0] A_POL   = 12'h40C;
  localparam logic [11:0] A_MASK  = 12'h410;
  localparam logic [11:0] A_RAW   = 12'h414;
  localparam logic [11:0] A_MIS   = 12'h418;
  localparam logic [11:0] A_CLR   = 12'h41C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pin_data = '0;
  logic [7:0]  pin_dir = '0;
  logic        reg_wr_en = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    bit          is_irq;
    logic [11:0] addr;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];

  always #2000 clk = ~clk;

  gpio_irq_detect u_gpio_irq_detect (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_data  (pin_data),
    .pin_dir   (pin_dir),
    .reg_wr_en (reg_wr_en),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq       (irq)
  );

  // Driver tasks: entered at a falling edge, return at the next falling edge
  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    reg_wr_en = 1'b1;
    reg_addr  = a;
    reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic set_pins(input logic [7:0] d);
    pin_data = d;
    @(negedge clk);
  endtask

  task automatic set_dir(input logic [7:0] d);
    pin_dir = d;
    @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic expect_reg(input logic [11:0] a, input logic [31:0] e, input string tag);
    item_t it;
    reg_addr  = a;
    it.is_irq = 1'b0;
    it.addr   = a;
    it.exp    = e;
    it.tag    = tag;
    sb.push_back(it);
    @(negedge clk);
  endtask

  task automatic expect_irq(input logic e, input string tag);
    item_t it;
    it.is_irq = 1'b1;
    it.addr   = reg_addr;
    it.exp    = {31'd0, e};
    it.tag    = tag;
    sb.push_back(it);
    @(negedge clk);
  endtask

  // Monitor: compares each expected item mid-way through the low phase
  initial begin
    forever begin
      item_t it;
      logic [31:0] act;
      wait (sb.size() != 0);
      #1000;
      it  = sb.pop_front();
      act = it.is_irq ? {31'd0, irq} : reg_rdata;
      n_checks++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.addr, act, it.exp);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    expect_reg(A_SENSE, 32'h0, "R1 sense reset");
    expect_reg(A_DUAL,  32'h0, "R1 dual reset");
    expect_reg(A_POL,   32'h0, "R1 pol reset");
    expect_reg(A_MASK,  32'h0, "R1 mask reset");
    expect_reg(A_RAW,   32'h0, "R1 raw reset");
    expect_irq(1'b0, "R1 irq reset");

    // R3: rising edge on pin 0
    wr(A_POL, 8'h01);
    set_pins(8'h01);
    expect_reg(A_RAW, 32'h01, "R3 rising sets");
    expect_reg(A_MIS, 32'h00, "R7 masked off");
    expect_irq(1'b0, "R7 irq masked off");
    wr(A_CLR, 8'h01);
    expect_reg(A_RAW, 32'h00, "R6 clear bit0");
    set_pins(8'h00);
    expect_reg(A_RAW, 32'h00, "R3 falling ignored on rising pin");

    // R3: falling edge on pin 1
    set_pins(8'h02);
    expect_reg(A_RAW, 32'h00, "R3 rising ignored on falling pin");
    set_pins(8'h00);
    expect_reg(A_RAW, 32'h02, "R3 falling sets");

    // R4: dual edge on pin 2
    wr(A_DUAL, 8'h04);
    set_pins(8'h04);
    expect_reg(A_RAW, 32'h06, "R4 dual rising");
    wr(A_CLR, 8'h00);
    expect_reg(A_RAW, 32'h06, "R6 zero write keeps");
    wr(A_CLR, 8'h06);
    expect_reg(A_RAW, 32'h00, "R6 clear two bits");
    set_pins(8'h00);
    expect_reg(A_RAW, 32'h04, "R4 dual falling");
    wr(A_CLR, 8'h04);

    // R2: output pin does not report a change
    wr(A_POL, 8'h09);
    set_dir(8'h08);
    set_pins(8'h08);
    expect_reg(A_RAW, 32'h00, "R2 output pin ignored");
    set_dir(8'h00);
    expect_reg(A_RAW, 32'h00, "R2 history refreshed while output");

    // R5 / R9: level mode on pins 4 (high) and 5 (low)
    wr(A_POL, 8'h19);
    wr(A_SENSE, 8'h30);
    expect_reg(A_RAW, 32'h00, "R9 level one clock after write");
    expect_reg(A_RAW, 32'h20, "R5 low level sets");
    set_pins(8'h18);
    expect_reg(A_RAW, 32'h30, "R5 high level sets");
    wr(A_CLR, 8'h30);
    expect_reg(A_RAW, 32'h00, "R6 clear wins over level");
    expect_reg(A_RAW, 32'h30, "R6 level sets again");

    // R7: mask gating
    wr(A_MASK, 8'h10);
    expect_irq(1'b1, "R7 irq asserted");
    expect_reg(A_MIS, 32'h10, "R7 masked read");
    wr(A_MASK, 8'h00);
    expect_irq(1'b0, "R7 irq deasserted");
    wr(A_MASK, 8'h20);
    expect_irq(1'b1, "R7 irq on bit5");

    // R8: register map readback
    expect_reg(A_MASK,  32'h20, "R8 mask readback");
    expect_reg(A_SENSE, 32'h30, "R8 sense readback");
    expect_reg(A_DUAL,  32'h04, "R8 dual readback");
    expect_reg(A_POL,   32'h19, "R8 pol readback");
    expect_reg(A_CLR,   32'h00, "R8 clear offset reads zero");
    expect_reg(12'h420, 32'h00, "R8 unmapped reads zero");

    // R5: leaving level mode stops re-setting
    wr(A_SENSE, 8'h00);
    wr(A_CLR, 8'hFF);
    expect_reg(A_RAW, 32'h00, "R5 cleared after sense off");
    expect_reg(A_RAW, 32'h00, "R5 no level set after sense off");
    expect_irq(1'b0, "R7 irq low after clear");

    wait (sb.size() == 0);
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule